// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block is the digital front end of a four-channel, 12-bit digital-to-analog converter. A host writes one 16-bit word per frame over a three-wire serial link: an active-low frame signal brackets the transfer, and data bits are captured on falling edges of the serial clock. Each completed word is decoded into a channel address, a reference-buffer select bit and a 12-bit code. The buffer bit and code are then written into that channel's input register.

Each channel has two register stages. An active-low load strobe copies all four input registers into the DAC registers at once, so the analog outputs can be updated together. Holding the strobe low makes each DAC register follow its input register. An active-low clear zeroes both stages. When chaining is enabled, the shift register's MSB is driven on a serial output, changing after rising serial-clock edges, so several devices can be cascaded. In that mode a word is committed when the frame ends.

The serial pins and control strobes are asynchronous to the block clock `clk`. They are resynchronised and edge-detected inside the block, so the serial clock must stay well below the block clock. An active-low power-down input is passed to all channels together.

Top module: `qdac_front`

## Requirements
- R1: After reset, every DAC code, every reference-buffer bit, `ser_dout` and `powered_down` are 0.
- R2: With `chain_en` low, the 16th falling `ser_clk` edge of a frame commits the word (MSB first). Bits [15:14] select the channel: 0=A, 1=B, 2=C, 3=D. Bit 13 is the buffer bit and bit 12 is ignored. Bits [11:0] are the code. The buffer bit and code go into that channel's input register.
- R3: If `frame_n` rises after fewer than 16 falling edges, no register changes.
- R4: While `load_n` is high, DAC codes and buffer bits do not change. A low `load_n` copies all four input registers into the DAC registers. Channel A is in `dac_codes[11:0]` and `ref_buf[0]`, and each following channel occupies the next slice.
- R5: With `load_n` held low, a committed word appears on the DAC outputs without any further strobe.
- R6: A low `clear_n` zeroes all input and DAC registers, including the buffer bits, and takes priority over a simultaneous load.
- R7: With `chain_en` high, a frame of 16 or more falling edges commits the last 16 bits shifted in when `frame_n` rises.
- R8: With `chain_en` high, `ser_dout` updates only after a rising `ser_clk` edge. It then carries the bit that entered the shift register 16 falling edges earlier.
- R9: With `chain_en` low, `ser_dout` stays 0.
- R10: `powered_down` is high while `pwrdn_n` is low, and low otherwise.
- R11: With `chain_en` low, falling edges after the 16th in one frame are ignored, and the committed word is the first 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data captured on falling edges |
| frame_n | input | 1 | Active-low frame enable |
| ser_din | input | 1 | Serial data in, MSB first |
| chain_en | input | 1 | High selects daisy-chain operation |
| load_n | input | 1 | Active-low transfer of input to DAC registers |
| clear_n | input | 1 | Active-low clear of all registers |
| pwrdn_n | input | 1 | Active-low power-down request |
| dac_codes | output | 48 | Four 12-bit DAC codes, channel A lowest |
| ref_buf | output | 4 | Reference-buffer select per channel, A in bit 0 |
| powered_down | output | 1 | All channels powered down |
| ser_dout | output | 1 | Daisy-chain serial output |

## Verification
The assertions check every cycle that an aborted frame leaves the input registers untouched, that a load copies the prior input contents, and that a clear empties both stages. They also check that a commit lands the decoded code in the addressed channel, that standalone framing stops counting at 16, and that `ser_dout` holds between rising edges and sits low outside chain mode. Only the bench scenarios can show the end-to-end effect of the serial word layout: which channel and slice each address reaches, the ignored reserved bit, and that chained frames commit the trailing 16 bits. The same applies to the exact bit sequence `ser_dout` produces across a long chained frame.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NCH    = 4;
  localparam int CODE_W = 12;
  localparam int WORD_W = 16;
  localparam int ADDR_W = $clog2(NCH);
  localparam int BUF_BIT = WORD_W - ADDR_W - 1;
  localparam int CNT_W  = $clog2(WORD_W + 2);

  typedef struct packed {
    logic                buf_sel;
    logic [CODE_W-1:0]   code;
  } chan_reg_t;

  function automatic logic [ADDR_W-1:0] word_chan(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: ADDR_W];
  endfunction

  function automatic logic [CODE_W-1:0] word_code(input logic [WORD_W-1:0] w);
    return w[CODE_W-1:0];
  endfunction

  function automatic logic word_buf(input logic [WORD_W-1:0] w);
    return w[BUF_BIT];
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/qdac_serial_rx.sv
module qdac_serial_rx import qdac_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              frame_n_s,
  input  logic              din_s,
  input  logic              chain_en_s,
  output logic [WORD_W-1:0] word,
  output logic              wr_pulse,
  output logic              frame_abort,
  output logic              dout
);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] SAT   = CNT_W'(WORD_W + 1);

  logic              sclk_d, frame_d;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic              done_q;

  // named internal events
  logic fall_evt, rise_evt, frame_end, shift_ok, chain_latch;
  assign fall_evt    = sclk_d & ~sclk_s & ~frame_n_s;
  assign rise_evt    = ~sclk_d & sclk_s;
  assign frame_end   = ~frame_d & frame_n_s;
  assign shift_ok    = chain_en_s | (cnt < FULL);
  assign chain_latch = frame_end & chain_en_s & (cnt >= FULL);
  assign frame_abort = frame_end & (cnt < FULL);
  assign wr_pulse    = done_q | chain_latch;
  assign word        = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      frame_d <= 1'b1;
      cnt <= '0;
      shreg <= '0;
      done_q <= 1'b0;
      dout <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      frame_d <= frame_n_s;
      done_q  <= fall_evt & ~chain_en_s & (cnt == LAST);
      if (frame_n_s) begin
        cnt <= '0;
      end else if (fall_evt && shift_ok) begin
        shreg <= {shreg[WORD_W-2:0], din_s};
        if (cnt != SAT) cnt <= cnt + 1'b1;
      end
      if (!chain_en_s)   dout <= 1'b0;
      else if (rise_evt) dout <= shreg[WORD_W-1];
    end
  end

  p_stop_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && !chain_en_s && cnt == FULL) |=> (cnt == FULL));
  p_dout_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_en_s |=> !dout);
  p_dout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en_s && !rise_evt) |=> $stable(dout));
  p_no_abort_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> !wr_pulse);
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs import qdac_pkg::*; (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_pulse,
  input  logic [WORD_W-1:0]       word,
  input  logic                    frame_abort,
  input  logic                    ld,
  input  logic                    clr,
  output logic [NCH*CODE_W-1:0]   dac_codes,
  output logic [NCH-1:0]          ref_buf
);
  chan_reg_t [NCH-1:0] inp;
  chan_reg_t [NCH-1:0] dac;
  logic      [NCH-1:0] wr_sel;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign wr_sel[i] = wr_pulse && (word_chan(word) == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         inp[i] <= '0;
      else if (clr)       inp[i] <= '0;
      else if (wr_sel[i]) inp[i] <= '{buf_sel: word_buf(word), code: word_code(word)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dac[i] <= '0;
      else if (clr) dac[i] <= '0;
      else if (ld)  dac[i] <= inp[i];
    end

    assign dac_codes[i*CODE_W +: CODE_W] = dac[i].code;
    assign ref_buf[i] = dac[i].buf_sel;

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[i] && !clr) |=> (inp[i].code == $past(word_code(word))));
  end

  p_abort_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_abort && !clr) |=> $stable(inp));
  p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (dac == $past(inp)));
  p_no_load_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !clr) |=> $stable(dac));
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (dac == '0 && inp == '0));
endmodule

// File: rtl/qdac_front.sv
module qdac_front import qdac_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_clk,
  input  logic                  frame_n,
  input  logic                  ser_din,
  input  logic                  chain_en,
  input  logic                  load_n,
  input  logic                  clear_n,
  input  logic                  pwrdn_n,
  output logic [NCH*CODE_W-1:0] dac_codes,
  output logic [NCH-1:0]        ref_buf,
  output logic                  powered_down,
  output logic                  ser_dout
);
  localparam int NSIG = 7;
  // order: pwrdn_n, clear_n, load_n, chain_en, din, frame_n, ser_clk
  localparam logic [NSIG-1:0] IDLE = 7'b111_0011;

  logic [NSIG-1:0] raw, syn;
  assign raw = {pwrdn_n, clear_n, load_n, chain_en, ser_din, frame_n, ser_clk};

  qdac_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  logic pd_s, clr_s, ld_s, chain_s, din_s, frame_s, sclk_s;
  assign {pd_s, clr_s, ld_s, chain_s, din_s, frame_s, sclk_s} = syn;

  logic [WORD_W-1:0] word;
  logic              wr_pulse, frame_abort;

  qdac_serial_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .frame_n_s(frame_s),
    .din_s(din_s), .chain_en_s(chain_s), .word(word), .wr_pulse(wr_pulse),
    .frame_abort(frame_abort), .dout(ser_dout)
  );

  qdac_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .word(word),
    .frame_abort(frame_abort), .ld(~ld_s), .clr(~clr_s),
    .dac_codes(dac_codes), .ref_buf(ref_buf)
  );

  assign powered_down = ~pd_s;

  p_pd_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_s) |-> powered_down);
endmodule

// File: tb/qdac_front_test.sv
module qdac_front_test;
  localparam int H = 6;

  logic clk = 0, rst_n = 0;
  logic ser_clk = 1, frame_n = 1, ser_din = 0, chain_en = 0;
  logic load_n = 1, clear_n = 1, pwrdn_n = 1;
  logic [47:0] dac_codes;
  logic [3:0]  ref_buf;
  logic        powered_down, ser_dout;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [11:0] e_inp_code [4];
  logic        e_inp_buf  [4];
  logic [11:0] e_dac_code [4];
  logic        e_dac_buf  [4];

  localparam logic [15:0] VEC [6] = '{16'h0ABC, 16'h6123, 16'hBFFF,
                                      16'hC001, 16'h2800, 16'h5555};

  always #2.5 clk = ~clk;

  qdac_front uut (.clk, .rst_n, .ser_clk, .frame_n, .ser_din, .chain_en,
    .load_n, .clear_n, .pwrdn_n, .dac_codes, .ref_buf, .powered_down, .ser_dout);

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    logic [47:0] ec;
    logic [3:0]  eb;
    for (int c = 0; c < 4; c++) begin
      ec[c*12 +: 12] = e_dac_code[c];
      eb[c] = e_dac_buf[c];
    end
    check({req, " codes"}, 64'(dac_codes), 64'(ec));
    check({req, " bufs"}, 64'(ref_buf), 64'(eb));
  endtask

  // note a committed word in the model
  task automatic model_write(input logic [15:0] w);
    e_inp_code[w[15:14]] = w[11:0];
    e_inp_buf[w[15:14]]  = w[13];
  endtask

  task automatic model_load();
    for (int c = 0; c < 4; c++) begin
      e_dac_code[c] = e_inp_code[c];
      e_dac_buf[c]  = e_inp_buf[c];
    end
  endtask

  // shift the low n bits of seq, MSB first; checks ser_dout after each rise
  task automatic send(input logic [31:0] seq, input int n, input string req);
    frame_n = 0;
    wait_n(H);
    for (int i = 1; i <= n; i++) begin
      ser_din = seq[n - i];
      wait_n(H);
      ser_clk = 0;
      wait_n(H);
      ser_clk = 1;
      wait_n(H);
      if (!chain_en)    check({req, " R9 dout low"}, 64'(ser_dout), 64'(0));
      else if (i >= 16) check({req, " R8 dout bit"}, 64'(ser_dout), 64'(seq[n + 15 - i]));
    end
    frame_n = 1;
    wait_n(10);
  endtask

  task automatic pulse_load();
    load_n = 0;
    wait_n(H);
    load_n = 1;
    wait_n(H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      e_inp_code[c] = 0; e_inp_buf[c] = 0; e_dac_code[c] = 0; e_dac_buf[c] = 0;
    end
    wait_n(4);
    rst_n = 1;
    wait_n(4);
    check_outputs("R1 reset");
    check("R1 dout", 64'(ser_dout), 64'(0));
    check("R1 pd", 64'(powered_down), 64'(0));

    // table walk: R2 decode, R4 hold then load
    for (int v = 0; v < 6; v++) begin
      send(32'(VEC[v]), 16, "R2");
      check_outputs("R4 hold before load");
      model_write(VEC[v]);
      pulse_load();
      model_load();
      check_outputs("R2 R4 after load");
    end

    // R3: aborted frame after 10 edges
    send(32'h0111 >> 6, 10, "R3");
    pulse_load();
    check_outputs("R3 abort no change");

    // R11: extra edges in standalone ignored
    send(32'h3456F, 20, "R11");
    model_write(16'h3456);
    pulse_load();
    model_load();
    check_outputs("R11 first 16 bits");

    // R5: load held low
    load_n = 0;
    wait_n(H);
    send(32'hC9AB, 16, "R5");
    model_write(16'hC9AB);
    model_load();
    check_outputs("R5 transparent load");

    // R6: clear with load also low
    clear_n = 0;
    wait_n(H);
    for (int c = 0; c < 4; c++) begin
      e_inp_code[c] = 0; e_inp_buf[c] = 0; e_dac_code[c] = 0; e_dac_buf[c] = 0;
    end
    check_outputs("R6 clear over load");
    clear_n = 1;
    load_n = 1;
    wait_n(H);
    check_outputs("R6 after clear");

    // R7/R8: chained frame of 20 edges, last 16 commit
    chain_en = 1;
    wait_n(H);
    send({12'h0, 4'hA, 16'hA765}, 20, "R7");
    model_write(16'hA765);
    pulse_load();
    model_load();
    check_outputs("R7 chain commit");
    chain_en = 0;
    wait_n(H);
    check("R9 dout after chain", 64'(ser_dout), 64'(0));

    // R10: power-down
    pwrdn_n = 0;
    wait_n(H);
    check("R10 pd asserted", 64'(powered_down), 64'(1));
    pwrdn_n = 1;
    wait_n(H);
    check("R10 pd released", 64'(powered_down), 64'(0));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule